// File: doc/BRIEF.md
# Flash Completion Poll Sequencer

This block waits, on behalf of a host, for a flash program or erase job to finish. After a start pulse it latches a poll address (any address inside the sector being erased, or any unprotected address during a full-chip erase) and the data byte the job is expected to leave there. It then reads that address over a simple request/acknowledge bus until the status byte reports completion or failure.

A read whose top data bit (bit 7) agrees with bit 7 of the expected byte ends the wait successfully. A disagreeing read with both error flags (bit 5, timeout, and bit 3) clear triggers a new read. If either flag is set, bit 7 may have changed in the same instant, so one more read is taken and only that recheck decides. A failed recheck, and a success when the configuration input selects it, is followed by one write of an identification-exit command. The sequence ends with a single-cycle done pulse that carries a pass flag.

States: `ST_IDLE` (waits for start), `ST_POLL` (first-look reads), `ST_RECHK` (recheck read after an error flag), `ST_EXIT` (exit-command write), `ST_FIN` (done pulse). Transitions: IDLE->POLL on start; POLL->POLL on a mismatch with flags clear; POLL->RECHK on a mismatch with a flag set; POLL or RECHK -> FIN on a match with mode 00/10/11, or -> EXIT on a match with mode 01; RECHK->EXIT on a mismatch; EXIT->FIN on the write acknowledge; FIN->IDLE always.

Top module: `poll_seq`

## Requirements
- R1: Out of reset the bus request, done and pass outputs are all low.
- R2: Every poll read is a request with write-enable low at the address latched at start.
- R3: A read whose bit 7 equals bit 7 of the expected byte, with mode 00, 10 or 11, gives done with pass high and no write.
- R4: A read whose bit 7 differs and whose bits 3 and 5 are both 0 is followed by another read.
- R5: A read whose bit 7 differs and whose bit 3 or bit 5 is 1 is followed by exactly one recheck read; a matching recheck gives pass.
- R6: A mismatching recheck gives one write of EXIT_DATA (default 0xF0) at EXIT_ADDR (default 0x00555), then done with pass low.
- R7: With mode 01, a success issues the same exit write before done with pass high.
- R8: A read where bit 7 matches while bit 3 or bit 5 is also set counts as success at once, with no recheck read.
- R9: A bus request, with its address and write-enable, stays unchanged until acknowledge.
- R10: A start pulse while a sequence is running is ignored; address and expected data stay as latched.
- R11: done lasts exactly one cycle per sequence, and pass is high only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a poll sequence |
| addr_i | input | AW | Poll address |
| exp_data_i | input | DW | Expected data byte |
| mode_i | input | 2 | Exit-on-success select (01 = write exit on success) |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid with it |
| bus_rdata_i | input | DW | Read data |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Result, valid with done |

## Verification
Two decisions can fall on one acknowledged read: the bit-7 match that ends polling and the error flags that would demand a recheck. The bench returns status bytes carrying a matching bit 7 together with bit 5 or bit 3, for expected bytes with bit 7 both high and low, and judges by the pass flag and by the read count staying at one. A second overlap, a start pulse arriving mid-sequence, is provoked with a different address and expected byte and judged by the addresses of later reads and the final result.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POLL  = 3'd1,
        ST_RECHK = 3'd2,
        ST_EXIT  = 3'd3,
        ST_FIN   = 3'd4
    } poll_state_t;

    localparam logic [1:0] MODE_EXIT_ON_OK = 2'b01;
endpackage

// File: rtl/poll_cmp.sv
module poll_cmp #(
    parameter int           DW        = 8,
    parameter logic [DW-1:0] POLL_MASK = 8'h80,
    parameter logic [DW-1:0] ERR_MASK  = 8'h28
) (
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] exp_i,
    output logic          match_o,
    output logic          err_o
);
    always_comb begin
        match_o = ~|((rdata_i ^ exp_i) & POLL_MASK);
        err_o   = |(rdata_i & ERR_MASK);
    end
endmodule

// File: rtl/poll_result.sv
module poll_result (
    input  logic fin_i,
    input  logic ok_i,
    output logic done_o,
    output logic pass_o
);
    always_comb begin
        done_o = fin_i;
        pass_o = fin_i & ok_i;
    end
endmodule

// File: rtl/poll_seq.sv
module poll_seq
    import poll_pkg::*;
#(
    parameter int            AW        = 20,
    parameter int            DW        = 8,
    parameter logic [DW-1:0] POLL_MASK = 8'h80,
    parameter logic [DW-1:0] ERR_MASK  = 8'h28,
    parameter logic [AW-1:0] EXIT_ADDR = 20'h00555,
    parameter logic [DW-1:0] EXIT_DATA = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [1:0]    mode_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          done_o,
    output logic          pass_o
);
    poll_state_t   st_q, st_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          exit_on_ok_q;
    logic          ok_q, ok_d;
    logic          bit_match, err_seen;
    logic          accept;

    poll_cmp #(.DW(DW), .POLL_MASK(POLL_MASK), .ERR_MASK(ERR_MASK)) u_cmp (
        .rdata_i (bus_rdata_i),
        .exp_i   (exp_q),
        .match_o (bit_match),
        .err_o   (err_seen)
    );

    assign accept = (st_q == ST_IDLE) && start_i;

    // next state
    always_comb begin
        st_d = st_q;
        ok_d = ok_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d = ST_POLL;
                    ok_d = 1'b0;
                end
            end
            ST_POLL: begin
                if (bus_ack_i) begin
                    if (bit_match) begin
                        ok_d = 1'b1;
                        st_d = exit_on_ok_q ? ST_EXIT : ST_FIN;
                    end else if (err_seen) begin
                        st_d = ST_RECHK;
                    end
                end
            end
            ST_RECHK: begin
                if (bus_ack_i) begin
                    ok_d = bit_match;
                    st_d = (!bit_match || exit_on_ok_q) ? ST_EXIT : ST_FIN;
                end
            end
            ST_EXIT: begin
                if (bus_ack_i) st_d = ST_FIN;
            end
            ST_FIN: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and latched job
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            ok_q         <= 1'b0;
            addr_q       <= '0;
            exp_q        <= '0;
            exit_on_ok_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ok_q <= ok_d;
            if (accept) begin
                addr_q       <= addr_i;
                exp_q        <= exp_data_i;
                exit_on_ok_q <= (mode_i == MODE_EXIT_ON_OK);
            end
        end
    end

    // outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = addr_q;
        bus_wdata_o = '0;
        unique case (st_q)
            ST_POLL, ST_RECHK: bus_req_o = 1'b1;
            ST_EXIT: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = EXIT_ADDR;
                bus_wdata_o = EXIT_DATA;
            end
            default: ;
        endcase
    end

    poll_result u_res (
        .fin_i  (st_q == ST_FIN),
        .ok_i   (ok_q),
        .done_o (done_o),
        .pass_o (pass_o)
    );

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !pass_o |-> $past(bus_req_o && bus_we_o && bus_ack_i));

    // R4
    retry_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POLL) && bus_ack_i && !bit_match && !err_seen |=> bus_req_o && !bus_we_o);

    // R10
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) && start_i |=> $stable(addr_q) && $stable(exp_q));
endmodule

// File: tb/poll_seq_bench.sv
module poll_seq_bench;
    localparam int AW = 20;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] exp_data_i = '0;
    logic [1:0]    mode_i = 2'b00;
    logic          bus_req_o, bus_we_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic          bus_ack_i;
    logic [DW-1:0] bus_rdata_i;
    logic          done_o, pass_o;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] stat [0:7];
    logic          clr = 1'b0;
    int            lat = 0;
    int            wcnt, rd_cnt, wr_cnt;
    logic [AW-1:0] last_rd_addr, wr_addr;
    logic [DW-1:0] wr_data;

    always #5 clk = ~clk;

    poll_seq u_poll_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .exp_data_i(exp_data_i), .mode_i(mode_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .done_o(done_o), .pass_o(pass_o)
    );

    // device model
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            bus_ack_i <= 1'b0; bus_rdata_i <= '0; wcnt <= 0;
            rd_cnt <= 0; wr_cnt <= 0; last_rd_addr <= '0; wr_addr <= '0; wr_data <= '0;
        end else if (bus_req_o && !bus_ack_i) begin
            if (wcnt >= lat) begin
                wcnt      <= 0;
                bus_ack_i <= 1'b1;
                if (bus_we_o) begin
                    wr_cnt  <= wr_cnt + 1;
                    wr_addr <= bus_addr_o;
                    wr_data <= bus_wdata_o;
                end else begin
                    bus_rdata_i  <= stat[rd_cnt % 8];
                    rd_cnt       <= rd_cnt + 1;
                    last_rd_addr <= bus_addr_o;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            bus_ack_i <= 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [DW-1:0] s0, s1, s2, s3, s4);
        stat[0] = s0; stat[1] = s1; stat[2] = s2; stat[3] = s3; stat[4] = s4;
        stat[5] = 8'h00; stat[6] = 8'h00; stat[7] = 8'h00;
    endtask

    // start a job, wait for done, check pass and one-cycle done
    task automatic run(input logic [AW-1:0] a, input logic [DW-1:0] e, input logic [1:0] m,
                       input logic exp_pass, input string tag);
        int n;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        addr_i = a; exp_data_i = e; mode_i = m; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        n = 0;
        while (!done_o && n < 500) begin @(negedge clk); n++; end
        chk({tag, " done seen"}, int'(done_o), 1);
        chk({tag, " pass"}, int'(pass_o), int'(exp_pass));
        @(negedge clk);
        chk("R11 done one cycle", int'(done_o), 0);
        chk("R11 pass low without done", int'(pass_o), 0);
    endtask

    task automatic t_reset();
        chk("R1 req after reset", int'(bus_req_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 pass after reset", int'(pass_o), 0);
    endtask

    task automatic t_quick_ok();
        load(8'h85, 0, 0, 0, 0);
        run(20'h1A2B3, 8'hA5, 2'b00, 1'b1, "R3");
        chk("R3 reads", rd_cnt, 1);
        chk("R3 no write", wr_cnt, 0);
        chk("R2 read address", int'(last_rd_addr), 'h1A2B3);
    endtask

    task automatic t_retry();
        load(8'h00, 8'h01, 8'h40, 8'h80, 0);
        run(20'h00040, 8'hA5, 2'b10, 1'b1, "R4");
        chk("R4 repeated reads", rd_cnt, 4);
        chk("R3 mode 10 no write", wr_cnt, 0);
    endtask

    task automatic t_recheck_ok();
        load(8'h20, 8'h80, 0, 0, 0);
        run(20'h00100, 8'hA5, 2'b11, 1'b1, "R5");
        chk("R5 one recheck", rd_cnt, 2);
        chk("R5 no write", wr_cnt, 0);
    endtask

    task automatic t_recheck_fail();
        load(8'h08, 8'h08, 8'h80, 0, 0);
        run(20'h00200, 8'hA5, 2'b00, 1'b0, "R6");
        chk("R6 reads", rd_cnt, 2);
        chk("R6 writes", wr_cnt, 1);
        chk("R6 exit addr", int'(wr_addr), 'h00555);
        chk("R6 exit data", int'(wr_data), 'hF0);
    endtask

    task automatic t_mode01();
        load(8'h80, 0, 0, 0, 0);
        run(20'h00300, 8'hA5, 2'b01, 1'b1, "R7");
        chk("R7 writes", wr_cnt, 1);
        chk("R7 exit data", int'(wr_data), 'hF0);
    endtask

    task automatic t_same_read();
        load(8'hA0, 0, 0, 0, 0);
        run(20'h00400, 8'hA5, 2'b00, 1'b1, "R8 bit7 high");
        chk("R8 single read", rd_cnt, 1);
        load(8'h80, 8'h7F, 0, 0, 0);
        run(20'h00400, 8'h12, 2'b00, 1'b1, "R8 bit7 low");
        chk("R8 no recheck", rd_cnt, 2);
    endtask

    task automatic t_slow_ack();
        lat = 3;
        load(8'h00, 8'h28, 8'h80, 0, 0);
        run(20'h00500, 8'hA5, 2'b00, 1'b1, "R9");
        chk("R9 reads with wait states", rd_cnt, 3);
        lat = 0;
    endtask

    task automatic t_busy_start();
        int n;
        load(8'h00, 8'h00, 8'h00, 8'h00, 8'h80);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        addr_i = 20'h01234; exp_data_i = 8'hA5; mode_i = 2'b00; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        addr_i = 20'h0BEEF; exp_data_i = 8'h00; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        n = 0;
        while (!done_o && n < 500) begin @(negedge clk); n++; end
        chk("R10 done", int'(done_o), 1);
        chk("R10 pass with first job", int'(pass_o), 1);
        chk("R10 address kept", int'(last_rd_addr), 'h01234);
        chk("R10 reads", rd_cnt, 5);
    endtask

    initial begin
        load(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_quick_ok();
        t_retry();
        t_recheck_ok();
        t_recheck_fail();
        t_mode01();
        t_same_read();
        t_slow_ack();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule